// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a parallel NOR-style flash. After software has launched an embedded program or erase operation in the device, the poller decides when that operation has ended and whether it succeeded. It does this by reading one chosen valid address over and over through a simple request/acknowledge read port and inspecting status bits in the returned byte.

Two methods are available, chosen per operation. The data-compare method checks bit 7 of the returned byte against bit 7 of the byte that should end up stored. The toggle method checks whether bit 6 flips between back-to-back reads. Both methods treat bit 5 as the device's timeout/error flag. When that flag is seen, the poller does not trust the read that carried it, because the status bits can settle in the same instant as the flag rises. It reads the device again before it gives a verdict. The result is reported as a one-cycle done pulse that comes together with exactly one of a pass pulse or a fail pulse.

Sending the program or erase command sequence, the low-level bus timing and any retry policy belong to other blocks.

Top module: `nor_done_poller`

## Requirements
- R1: A start pulse taken while idle latches the method select, the poll address and the expected byte. Every read of that operation uses the latched address. A start pulse while busy has no effect on the address or on the outcome.
- R2: Each read holds rd_req_o high until rd_ack_i is seen. The data byte is sampled only in the cycle where rd_ack_i is high. rd_req_o is low whenever the block is idle.
- R3: Data-compare method (mode_i = 0): if bit 7 of the read byte equals bit 7 of the expected byte, the operation ends with pass.
- R4: Data-compare method: if bit 7 differs and bit 5 of the same byte is 0, another read is issued and checked the same way.
- R5: Data-compare method: if bit 7 differs and bit 5 is 1, exactly one more read is made. The result is pass if its bit 7 equals expected bit 7, and fail otherwise.
- R6: Toggle method (mode_i = 1): reads are taken in pairs. If bit 6 is the same in both reads of a pair, the operation ends with pass.
- R7: Toggle method: if bit 6 differs within a pair and bit 5 of the pair's first read is 0, a new pair of reads starts.
- R8: Toggle method: if bit 6 differs within a pair and bit 5 of the pair's first read is 1, exactly two more reads are made. The result is pass if their bit 6 values are equal, and fail otherwise.
- R9: done_o is high for exactly one cycle, in the cycle after the acknowledge of the deciding read. In that cycle exactly one of pass_o and fail_o is high. Neither is high outside a done cycle.
- R10: abort_i while busy returns the block to idle on the next edge without a done pulse. This also holds when the abort comes in the same cycle as a deciding acknowledge.
- R11: After reset the block is idle, with rd_req_o, busy_o, done_o, pass_o and fail_o all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling; taken only while idle |
| mode_i | input | 1 | Method select: 0 data-compare, 1 toggle |
| addr_i | input | ADDR_W | Valid address to poll |
| expect_i | input | DATA_W | Byte being programmed; bit 7 is the compare target |
| abort_i | input | 1 | Drop the operation and return to idle |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Address of the read |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i is valid in this cycle |
| rd_data_i | input | DATA_W | Byte returned by the device |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation succeeded (with done_o) |
| fail_o | output | 1 | Operation failed (with done_o) |

## Verification
A wrong internal state shows at the ports as a wrong read count. The poller then asks for one read too many or too few before done_o rises, and this shows within one acknowledge of the divergence, because every read after the first is issued on the edge that consumes the previous acknowledge. A wrong latched toggle bit or error flag shows up as a pass where a fail is expected, or the reverse, at the end of the next pair. Sampling data outside the acknowledge cycle shows up at once, because the bench drives the opposite byte while acknowledge is low.

// File: rtl/poller_pkg.sv
package poller_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_DC_READ   = 3'd1,
      ST_DC_RECHK  = 3'd2,
      ST_TG_FIRST  = 3'd3,
      ST_TG_SECOND = 3'd4,
      ST_TG_RCHK_A = 3'd5,
      ST_TG_RCHK_B = 3'd6
   } poll_state_e;

   typedef enum logic [1:0] {
      VERDICT_NONE = 2'd0,
      VERDICT_PASS = 2'd1,
      VERDICT_FAIL = 2'd2
   } verdict_e;

   localparam logic METHOD_DATA   = 1'b0;
   localparam logic METHOD_TOGGLE = 1'b1;

endpackage

// File: rtl/poll_capture.sv
module poll_capture #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              expect_bit_i,
   output logic [ADDR_W-1:0] addr_q_o,
   output logic              expect_bit_q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q_o       <= '0;
         expect_bit_q_o <= 1'b0;
      end else if (accept_i) begin
         addr_q_o       <= addr_i;
         expect_bit_q_o <= expect_bit_i;
      end
   end

endmodule

// File: rtl/poll_sample.sv
module poll_sample #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int TOG_BIT  = 6,
   parameter int ERR_BIT  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              expect_bit_i,
   output logic              match_o,
   output logic              toggled_o,
   output logic              err_now_o,
   output logic              err_held_o
);

   logic tog_q;
   logic err_q;
   logic unused_rest;

   assign unused_rest = ^data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
         err_q <= 1'b0;
      end else if (load_i) begin
         tog_q <= data_i[TOG_BIT];
         err_q <= data_i[ERR_BIT];
      end
   end

   assign match_o    = (data_i[POLL_BIT] == expect_bit_i);
   assign toggled_o  = (data_i[TOG_BIT] != tog_q);
   assign err_now_o  = data_i[ERR_BIT];
   assign err_held_o = err_q;

endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
   import poller_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   input  logic     mode_i,
   input  logic     abort_i,
   input  logic     ack_i,
   input  logic     match_i,
   input  logic     toggled_i,
   input  logic     err_now_i,
   input  logic     err_held_i,
   output logic     accept_o,
   output logic     load_o,
   output logic     busy_o,
   output verdict_e verdict_o
);

   poll_state_e state_q;
   poll_state_e state_d;

   always_comb begin
      state_d   = state_q;
      accept_o  = 1'b0;
      load_o    = 1'b0;
      verdict_o = VERDICT_NONE;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               accept_o = 1'b1;
               state_d  = (mode_i == METHOD_TOGGLE) ? ST_TG_FIRST : ST_DC_READ;
            end
         end
         ST_DC_READ: begin
            if (ack_i) begin
               if (match_i) begin
                  verdict_o = VERDICT_PASS;
                  state_d   = ST_IDLE;
               end else if (err_now_i) begin
                  state_d = ST_DC_RECHK;
               end
            end
         end
         ST_DC_RECHK: begin
            if (ack_i) begin
               verdict_o = match_i ? VERDICT_PASS : VERDICT_FAIL;
               state_d   = ST_IDLE;
            end
         end
         ST_TG_FIRST: begin
            if (ack_i) begin
               load_o  = 1'b1;
               state_d = ST_TG_SECOND;
            end
         end
         ST_TG_SECOND: begin
            if (ack_i) begin
               if (!toggled_i) begin
                  verdict_o = VERDICT_PASS;
                  state_d   = ST_IDLE;
               end else if (err_held_i) begin
                  state_d = ST_TG_RCHK_A;
               end else begin
                  state_d = ST_TG_FIRST;
               end
            end
         end
         ST_TG_RCHK_A: begin
            if (ack_i) begin
               load_o  = 1'b1;
               state_d = ST_TG_RCHK_B;
            end
         end
         ST_TG_RCHK_B: begin
            if (ack_i) begin
               verdict_o = toggled_i ? VERDICT_FAIL : VERDICT_PASS;
               state_d   = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
      if (abort_i && (state_q != ST_IDLE)) begin
         state_d   = ST_IDLE;
         load_o    = 1'b0;
         verdict_o = VERDICT_NONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/poll_result.sv
module poll_result
   import poller_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  verdict_e verdict_i,
   output logic     done_o,
   output logic     pass_o,
   output logic     fail_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         pass_o <= 1'b0;
         fail_o <= 1'b0;
      end else begin
         done_o <= (verdict_i != VERDICT_NONE);
         pass_o <= (verdict_i == VERDICT_PASS);
         fail_o <= (verdict_i == VERDICT_FAIL);
      end
   end

endmodule

// File: rtl/nor_done_poller.sv
module nor_done_poller
   import poller_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int TOG_BIT  = 6,
   parameter int ERR_BIT  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] expect_i,
   input  logic              abort_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              pass_o,
   output logic              fail_o
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (POLL_BIT >= DATA_W || TOG_BIT >= DATA_W || ERR_BIT >= DATA_W) begin : g_bad_bit
         $error("status bit positions must lie inside DATA_W");
      end
      if (POLL_BIT == TOG_BIT || POLL_BIT == ERR_BIT || TOG_BIT == ERR_BIT) begin : g_same_bit
         $error("status bit positions must be distinct");
      end
   endgenerate

   logic     accept;
   logic     load;
   logic     expect_q;
   logic     match;
   logic     toggled;
   logic     err_now;
   logic     err_held;
   verdict_e verdict;
   logic     unused_expect;

   assign unused_expect = ^expect_i;

   poll_capture #(.ADDR_W(ADDR_W)) u_capture (
      .clk            (clk),
      .rst_n          (rst_n),
      .accept_i       (accept),
      .addr_i         (addr_i),
      .expect_bit_i   (expect_i[POLL_BIT]),
      .addr_q_o       (rd_addr_o),
      .expect_bit_q_o (expect_q)
   );

   poll_sample #(
      .DATA_W   (DATA_W),
      .POLL_BIT (POLL_BIT),
      .TOG_BIT  (TOG_BIT),
      .ERR_BIT  (ERR_BIT)
   ) u_sample (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load),
      .data_i       (rd_data_i),
      .expect_bit_i (expect_q),
      .match_o      (match),
      .toggled_o    (toggled),
      .err_now_o    (err_now),
      .err_held_o   (err_held)
   );

   poll_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .mode_i     (mode_i),
      .abort_i    (abort_i),
      .ack_i      (rd_ack_i),
      .match_i    (match),
      .toggled_i  (toggled),
      .err_now_i  (err_now),
      .err_held_i (err_held),
      .accept_o   (accept),
      .load_o     (load),
      .busy_o     (busy_o),
      .verdict_o  (verdict)
   );

   poll_result u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .verdict_i (verdict),
      .done_o    (done_o),
      .pass_o    (pass_o),
      .fail_o    (fail_o)
   );

   assign rd_req_o = busy_o;

endmodule

// File: rtl/poller_checker.sv
module poller_checker #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              abort_i,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_ack_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              pass_o,
   input logic              fail_o
);

   p_verdict_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pass_o != fail_o));

   p_no_stray_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (!pass_o && !fail_o));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(rd_ack_i && rd_req_o));

   p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i && !abort_i) |=> rd_req_o);

   p_addr_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (!busy_o || $stable(rd_addr_o)));

   p_busy_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(rd_addr_o));

   p_abort_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && abort_i) |=> (!busy_o && !done_o));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rd_req_o);

endmodule

bind nor_done_poller poller_checker #(.ADDR_W(ADDR_W)) u_poller_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .abort_i   (abort_i),
   .rd_req_o  (rd_req_o),
   .rd_addr_o (rd_addr_o),
   .rd_ack_i  (rd_ack_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .pass_o    (pass_o),
   .fail_o    (fail_o)
);

// File: tb/tb_nor_done_poller.sv
`timescale 1ns/1ps
module tb_nor_done_poller;

   localparam int ADDR_W = 20;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              mode_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [DATA_W-1:0] expect_i = '0;
   logic              abort_i = 1'b0;
   logic              rd_req_o;
   logic [ADDR_W-1:0] rd_addr_o;
   logic              rd_ack_i = 1'b0;
   logic [DATA_W-1:0] rd_data_i = '0;
   logic              busy_o, done_o, pass_o, fail_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   nor_done_poller #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .addr_i(addr_i), .expect_i(expect_i), .abort_i(abort_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
      .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
      .pass_o(pass_o), .fail_o(fail_o)
   );

   // mode: 0 data-compare, 1 toggle. byte k of rd sits at bits 8k+7:8k.
   typedef struct packed {
      logic        mode;
      logic [7:0]  exp_byte;
      logic [47:0] rd;
      logic [2:0]  nrd;
      logic        ok;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{1'b0, 8'hA5, 48'h000000000080, 3'd1, 1'b1},   // R3 match at once
      '{1'b0, 8'hA5, 48'h000000800000, 3'd3, 1'b1},   // R4 two re-reads
      '{1'b0, 8'hA5, 48'h000000008020, 3'd2, 1'b1},   // R5 recheck pass
      '{1'b0, 8'hA5, 48'h000000002020, 3'd2, 1'b0},   // R5 recheck fail
      '{1'b0, 8'h00, 48'h00000000007F, 3'd1, 1'b1},   // R3 expected bit 0
      '{1'b1, 8'hA5, 48'h000000004040, 3'd2, 1'b1},   // R6 stable pair
      '{1'b1, 8'hA5, 48'h000000000040, 3'd4, 1'b1},   // R7 new pair then pass
      '{1'b1, 8'hA5, 48'h000000000060, 3'd4, 1'b1},   // R8 recheck pass
      '{1'b1, 8'hA5, 48'h000000400060, 3'd4, 1'b0},   // R8 recheck fail
      '{1'b1, 8'hA5, 48'h400040200040, 3'd6, 1'b0}    // R7 then R8 fail
   };

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   endtask

   task automatic wait_req();
      for (int g = 0; g < 50 && !rd_req_o; g++) @(negedge clk);
   endtask

   task automatic run_op(input vec_t v, input logic [ADDR_W-1:0] a,
                         input int dly, input bit poke, input string tag);
      @(negedge clk);
      start_i  = 1'b1;
      mode_i   = v.mode;
      addr_i   = a;
      expect_i = v.exp_byte;
      @(negedge clk);
      start_i  = 1'b0;
      mode_i   = ~v.mode;
      addr_i   = ~a;
      expect_i = ~v.exp_byte;
      for (int k = 0; k < int'(v.nrd); k++) begin
         wait_req();
         check(rd_req_o == 1'b1, "R2", {tag, " request"}, rd_req_o, 1);
         check(rd_addr_o == a, "R1", {tag, " address"}, rd_addr_o, a);
         rd_data_i = ~v.rd[8*k +: 8];
         if (poke && k == 0) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
         end
         for (int w = 0; w < dly; w++) begin
            @(negedge clk);
            check(rd_req_o && !done_o, "R2", {tag, " wait without ack"}, rd_req_o, 1);
         end
         rd_ack_i  = 1'b1;
         rd_data_i = v.rd[8*k +: 8];
         @(negedge clk);
         rd_ack_i  = 1'b0;
         rd_data_i = ~v.rd[8*k +: 8];
         if (k < int'(v.nrd) - 1) begin
            check(done_o == 1'b0, "R9", {tag, " early done"}, done_o, 0);
         end else begin
            check(done_o == 1'b1, "R9", {tag, " done"}, done_o, 1);
            check(pass_o == v.ok, v.mode ? "R6" : "R3", {tag, " pass"}, pass_o, v.ok);
            check(fail_o == !v.ok, "R9", {tag, " fail"}, fail_o, !v.ok);
         end
      end
      @(negedge clk);
      check(!done_o && !busy_o && !rd_req_o, "R9", {tag, " back to idle"},
            {done_o, busy_o, rd_req_o}, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not finish");
      report();
   end

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      check({rd_req_o, busy_o, done_o, pass_o, fail_o} == 5'b0, "R11", "in reset",
            {rd_req_o, busy_o, done_o, pass_o, fail_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({rd_req_o, busy_o, done_o, pass_o, fail_o} == 5'b0, "R11", "after reset",
            {rd_req_o, busy_o, done_o, pass_o, fail_o}, 0);

      // vector walk (R3..R8)
      for (int i = 0; i < 10; i++) begin
         run_op(VECS[i], ADDR_W'(20'h1234 + i * 20'h111), i % 3, 1'b0,
                $sformatf("vec%0d", i));
      end

      // R1: start while busy is ignored (toggle fail case and data recheck)
      run_op(VECS[8], 20'hABCDE, 1, 1'b1, "R1 busy start tg");
      run_op(VECS[2], 20'h0F0F0, 2, 1'b1, "R1 busy start dc");

      // R10: abort while waiting for ack
      @(negedge clk);
      start_i = 1'b1; mode_i = 1'b0; addr_i = 20'h00042; expect_i = 8'h80;
      @(negedge clk);
      start_i = 1'b0;
      wait_req();
      abort_i = 1'b1;
      rd_data_i = 8'h80;
      @(negedge clk);
      abort_i = 1'b0;
      check(!busy_o && !rd_req_o && !done_o, "R10", "abort idle",
            {busy_o, rd_req_o, done_o}, 0);
      for (int w = 0; w < 3; w++) begin
         @(negedge clk);
         check(!done_o && !rd_req_o, "R10", "no done after abort", done_o, 0);
      end

      // R10: abort in the same cycle as a deciding ack
      start_i = 1'b1; mode_i = 1'b0; addr_i = 20'h00043; expect_i = 8'h80;
      @(negedge clk);
      start_i = 1'b0;
      wait_req();
      abort_i = 1'b1; rd_ack_i = 1'b1; rd_data_i = 8'h80;
      @(negedge clk);
      abort_i = 1'b0; rd_ack_i = 1'b0;
      check(!done_o && !pass_o && !busy_o, "R10", "abort beats ack",
            {done_o, pass_o, busy_o}, 0);

      // R2: ack without request in idle has no effect
      rd_ack_i = 1'b1; rd_data_i = 8'h80;
      @(negedge clk);
      rd_ack_i = 1'b0;
      @(negedge clk);
      check(!done_o && !busy_o, "R2", "stray ack in idle", {done_o, busy_o}, 0);

      // block still healthy afterwards
      run_op(VECS[5], 20'h7777, 0, 1'b0, "after abort");

      report();
   end

endmodule